// File: doc/BRIEF.md
# NAND Controller Configuration and Interrupt Register File

This block is the software-visible register file of a NAND flash controller. It holds a packed geometry configuration word, a page index, a flow-control word and a burst-control word, and it turns the packed geometry word into decoded values for the sequencer: page bytes, erase-block bytes, address-cycle count and device bytes. It also keeps four sticky event flags that the sequencer raises, and a single interrupt output that combines those flags with a per-event enable and a global enable.

Software reaches the registers through a simple 32-bit request port. Every request gets a one-cycle-later response. Only full-word, word-aligned accesses take effect. Event flags are cleared by writing ones to a dedicated clear register. A handful of read-only words return fixed identification, page-count and PIO-ready values. Sequencing of the NAND bus itself lives elsewhere.

Top module: `nfc_cfg_regs`

## Requirements
- R1: `page_bytes` is 512 when geometry bits 9:8 are 0, 4096 when they are 2, and 2048 otherwise.
- R2: `block_bytes` equals `page_bytes` shifted left by 4 plus geometry bits 17:16.
- R3: `addr_cycles` is 3 plus geometry bits 11:10, and `dev_bytes` is 2 to the power of 24 plus geometry bits 7:4.
- R4: A write to the page index register (offset 0x14) keeps only bits 25:0, which appear on `page_index` and read back with bits 31:26 zero.
- R5: A write to the interrupt enable register (offset 0x08) stores the value ANDed with 0x8F. `irq` is high exactly when enable bit 7 is set and, for some k in 0..3, enable bit k and status bit k+2 are both set. `irq` follows any register or flag change in the same cycle the change lands.
- R6: A write to the clear register (offset 0x04) clears status bit k+2 for each set data bit k in 3:0, and data bits 31:4 have no effect. A flag raised in the same cycle as its clear stays set. The clear register reads 0.
- R7: A pulse on `evt_set[k]` sets status bit k+2 (status register, offset 0x00), and the bit stays set until it is cleared. Status bits 31:6 and 1:0 read 0.
- R8: `bus_16bit` equals bit 4 of the flow-control register (offset 0x0C). The geometry (0x10), flow-control and burst (0x18) registers read back all 32 written bits.
- R9: The revision word (0x20) reads 0x00010100, the hardware configuration word (0x24) reads 0x00081601, the page-count word (0x28) reads 1 and the PIO-ready word (0x2C) reads 1.
- R10: A request whose byte enables are not 4'hF, or whose address bits 1:0 are not zero, changes no register, and if it is a read it returns 0. A read of an unmapped offset returns 0.
- R11: Reset clears every register and flag. While reset is held and right after it, `irq` is 0, `page_bytes` is 512, `block_bytes` is 8192, `addr_cycles` is 3, `dev_bytes` is 2^24 and `bus_16bit` is 0.
- R12: Each accepted request produces `rsp_valid` high in the following cycle. For a read, `rsp_rdata` carries the addressed word in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| evt_set | input | 4 | Event pulses from the sequencer, setting status bits 5:2 |
| irq | output | 1 | Interrupt request |
| page_bytes | output | 13 | Decoded page size in bytes |
| block_bytes | output | 20 | Decoded erase-block size in bytes |
| addr_cycles | output | 3 | Number of address cycles |
| dev_bytes | output | 40 | Decoded device size in bytes |
| page_index | output | 26 | Current page index |
| bus_16bit | output | 1 | 1 selects a 16-bit NAND data bus |

## Verification
The bench sweeps all 1024 combinations of the four geometry fields, with unrelated bits set. A decoder that treats page code 3 as 4096, or that adds the block shift to the wrong base, would produce a mismatch there. It crosses every enable pattern, with the global enable on and off, against every status pattern. That exposes an interrupt that ignores the global enable, that pairs enable bit k with the wrong status bit, or that leaks the masked enable bits 6:4. Directed cases cover partial clears, clear data above bit 3, a flag raised in the same cycle as its clear, and partial-width or misaligned writes. A design that let a clear beat a new flag would lose that event, and one that honoured narrow writes would corrupt the geometry.

// File: rtl/nfc_cfg_pkg.sv
package nfc_cfg_pkg;

    // Bus shape
    parameter int DATA_W     = 32;
    parameter int ADDR_W     = 12;

    // Register content widths
    parameter int PAGE_IDX_W = 26;
    parameter int NUM_EVT    = 4;
    parameter int EVT_BASE   = 2;   // status bit of event 0
    parameter int IEN_W      = 8;
    parameter int IEN_GLOBAL = 7;

    // Decoded geometry widths
    parameter int PAGE_W     = 13;
    parameter int BLK_W      = 20;
    parameter int DEV_W      = 40;

    // Geometry field positions
    parameter int FLD_DEV_LSB  = 4;
    parameter int FLD_PAGE_LSB = 8;
    parameter int FLD_AC_LSB   = 10;
    parameter int FLD_BLK_LSB  = 16;
    parameter int FLOW_BUS16   = 4;

    // Decoding bases
    parameter int BLK_SHIFT_BASE = 4;
    parameter int AC_BASE        = 3;
    parameter int DEV_LOG2_BASE  = 24;

    // Fixed read-only contents
    parameter logic [DATA_W-1:0] REV_VALUE   = 32'h0001_0100;
    parameter logic [DATA_W-1:0] HWCFG_VALUE = 32'h0008_1601;
    parameter logic [DATA_W-1:0] PGCNT_VALUE = 32'h0000_0001;
    parameter logic [DATA_W-1:0] PIORDY_VALUE = 32'h0000_0001;

    localparam logic [IEN_W-1:0] IEN_MASK =
        IEN_W'((1 << IEN_GLOBAL) | ((1 << NUM_EVT) - 1));
    localparam int BE_W = DATA_W / 8;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_FLOW   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_GEOM   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_PAGE   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_BURST  = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_REV    = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_HWCFG  = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_PGCNT  = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_PIORDY = 12'h02C;

    typedef struct packed {
        logic [DATA_W-1:0]     geom;
        logic [DATA_W-1:0]     flow;
        logic [DATA_W-1:0]     burst;
        logic [PAGE_IDX_W-1:0] page;
        logic                  rsp_valid;
        logic [DATA_W-1:0]     rsp_rdata;
    } cfg_state_t;

    typedef struct packed {
        logic [IEN_W-1:0]   ien;
        logic [NUM_EVT-1:0] sts;
        logic               irq;
    } irq_state_t;

endpackage

// File: rtl/nfc_geom_decode.sv
module nfc_geom_decode
    import nfc_cfg_pkg::*;
(
    input  logic [1:0]        page_code,
    input  logic [1:0]        blk_code,
    input  logic [1:0]        ac_code,
    input  logic [3:0]        dev_code,
    output logic [PAGE_W-1:0] page_bytes,
    output logic [BLK_W-1:0]  block_bytes,
    output logic [2:0]        addr_cycles,
    output logic [DEV_W-1:0]  dev_bytes
);

    always_comb begin
        unique case (page_code)
            2'd0:    page_bytes = PAGE_W'(512);
            2'd2:    page_bytes = PAGE_W'(4096);
            default: page_bytes = PAGE_W'(2048);
        endcase
        block_bytes = BLK_W'(page_bytes) << (BLK_SHIFT_BASE + int'(blk_code));
        addr_cycles = 3'(AC_BASE) + {1'b0, ac_code};
        dev_bytes   = DEV_W'(1) << (DEV_LOG2_BASE + int'(dev_code));
    end

endmodule

// File: rtl/nfc_irq_unit.sv
module nfc_irq_unit
    import nfc_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ien_we,
    input  logic               clr_we,
    input  logic [IEN_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt_set,
    output logic [IEN_W-1:0]   ien,
    output logic [NUM_EVT-1:0] sts,
    output logic               irq
);

    irq_state_t         st_q, st_d;
    logic [NUM_EVT-1:0] sts_next;

    // A raised event beats a clear of the same flag
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_flag
        assign sts_next[k] = evt_set[k] | (st_q.sts[k] & ~(clr_we & wdata[k]));
    end

    always_comb begin
        st_d     = st_q;
        st_d.sts = sts_next;
        if (ien_we) begin
            st_d.ien = wdata & IEN_MASK;
        end
        st_d.irq = st_d.ien[IEN_GLOBAL] & (|(st_d.ien[NUM_EVT-1:0] & st_d.sts));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien = st_q.ien;
    assign sts = st_q.sts;
    assign irq = st_q.irq;

endmodule

// File: rtl/nfc_rd_mux.sv
module nfc_rd_mux
    import nfc_cfg_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_EVT-1:0]    sts,
    input  logic [IEN_W-1:0]      ien,
    input  logic [DATA_W-1:0]     flow,
    input  logic [DATA_W-1:0]     geom,
    input  logic [PAGE_IDX_W-1:0] page,
    input  logic [DATA_W-1:0]     burst,
    output logic [DATA_W-1:0]     rdata
);

    always_comb begin
        unique case (addr)
            OFS_STATUS: rdata = DATA_W'(sts) << EVT_BASE;
            OFS_IEN:    rdata = DATA_W'(ien);
            OFS_FLOW:   rdata = flow;
            OFS_GEOM:   rdata = geom;
            OFS_PAGE:   rdata = DATA_W'(page);
            OFS_BURST:  rdata = burst;
            OFS_REV:    rdata = REV_VALUE;
            OFS_HWCFG:  rdata = HWCFG_VALUE;
            OFS_PGCNT:  rdata = PGCNT_VALUE;
            OFS_PIORDY: rdata = PIORDY_VALUE;
            default:    rdata = '0;   // clear register and holes
        endcase
    end

endmodule

// File: rtl/nfc_cfg_regs.sv
module nfc_cfg_regs
    import nfc_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [BE_W-1:0]       req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    input  logic [NUM_EVT-1:0]    evt_set,
    output logic                  irq,
    output logic [PAGE_W-1:0]     page_bytes,
    output logic [BLK_W-1:0]      block_bytes,
    output logic [2:0]            addr_cycles,
    output logic [DEV_W-1:0]      dev_bytes,
    output logic [PAGE_IDX_W-1:0] page_index,
    output logic                  bus_16bit
);

    cfg_state_t         st_q, st_d;
    logic               full_word;
    logic               wr_ok;
    logic               rd_ok;
    logic               bad_wr;
    logic               ien_we;
    logic               clr_we;
    logic [IEN_W-1:0]   ien_q;
    logic [NUM_EVT-1:0] sts_q;
    logic [DATA_W-1:0]  mux_rdata;
    logic [DATA_W-1:0]  geom_q;

    assign full_word = (req_be == '1) && (req_addr[1:0] == 2'b00);
    assign wr_ok     = req_valid & req_write & full_word;
    assign rd_ok     = req_valid & ~req_write & full_word;
    assign bad_wr    = req_valid & req_write & ~full_word;
    assign ien_we    = wr_ok && (req_addr == OFS_IEN);
    assign clr_we    = wr_ok && (req_addr == OFS_CLEAR);
    assign geom_q    = st_q.geom;

    nfc_irq_unit u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_we  (ien_we),
        .clr_we  (clr_we),
        .wdata   (req_wdata[IEN_W-1:0]),
        .evt_set (evt_set),
        .ien     (ien_q),
        .sts     (sts_q),
        .irq     (irq)
    );

    nfc_rd_mux u_mux (
        .addr  (req_addr),
        .sts   (sts_q),
        .ien   (ien_q),
        .flow  (st_q.flow),
        .geom  (st_q.geom),
        .page  (st_q.page),
        .burst (st_q.burst),
        .rdata (mux_rdata)
    );

    nfc_geom_decode u_geom (
        .page_code   (st_q.geom[FLD_PAGE_LSB +: 2]),
        .blk_code    (st_q.geom[FLD_BLK_LSB +: 2]),
        .ac_code     (st_q.geom[FLD_AC_LSB +: 2]),
        .dev_code    (st_q.geom[FLD_DEV_LSB +: 4]),
        .page_bytes  (page_bytes),
        .block_bytes (block_bytes),
        .addr_cycles (addr_cycles),
        .dev_bytes   (dev_bytes)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_rdata = rd_ok ? mux_rdata : '0;
        if (wr_ok) begin
            unique case (req_addr)
                OFS_FLOW:  st_d.flow  = req_wdata;
                OFS_GEOM:  st_d.geom  = req_wdata;
                OFS_PAGE:  st_d.page  = req_wdata[PAGE_IDX_W-1:0];
                OFS_BURST: st_d.burst = req_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_rdata  = st_q.rsp_rdata;
    assign page_index = st_q.page;
    assign bus_16bit  = st_q.flow[FLOW_BUS16];

endmodule

// File: rtl/nfc_cfg_regs_chk.sv
module nfc_cfg_regs_chk
    import nfc_cfg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ien_we,
    input logic               clr_we,
    input logic               bad_wr,
    input logic [DATA_W-1:0]  req_wdata,
    input logic [NUM_EVT-1:0] evt_set,
    input logic [IEN_W-1:0]   ien_q,
    input logic [NUM_EVT-1:0] sts_q,
    input logic [DATA_W-1:0]  geom_q,
    input logic [PAGE_W-1:0]  page_bytes,
    input logic               irq
);

    // R1: exactly one size bit set in the decoded page size
    a_r1_page_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(page_bytes) == 1);

    // R5: enable write lands masked
    a_r5_ien_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ien_we |=> ien_q == ($past(req_wdata[IEN_W-1:0]) & IEN_MASK));

    // R5: no interrupt without the global enable
    a_r5_irq_global: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q[IEN_GLOBAL] |-> !irq);

    // R5: interrupt needs an enabled pending flag
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((ien_q[NUM_EVT-1:0] & sts_q) != '0));

    // R6: clear with no competing event empties the named flags
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && evt_set == '0) |=> ((sts_q & $past(req_wdata[NUM_EVT-1:0])) == '0));

    // R7: raised flags are set next cycle
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((sts_q & $past(evt_set)) == $past(evt_set)));

    // R10: narrow or misaligned writes leave the registers alone
    a_r10_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> ($stable(geom_q) && $stable(ien_q)));

endmodule

bind nfc_cfg_regs nfc_cfg_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien_we     (ien_we),
    .clr_we     (clr_we),
    .bad_wr     (bad_wr),
    .req_wdata  (req_wdata),
    .evt_set    (evt_set),
    .ien_q      (ien_q),
    .sts_q      (sts_q),
    .geom_q     (geom_q),
    .page_bytes (page_bytes),
    .irq        (irq)
);

// File: tb/nfc_cfg_regs_bench.sv
module nfc_cfg_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  evt_set = '0;
    logic        irq;
    logic [12:0] page_bytes;
    logic [19:0] block_bytes;
    logic [2:0]  addr_cycles;
    logic [39:0] dev_bytes;
    logic [25:0] page_index;
    logic        bus_16bit;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    nfc_cfg_regs u_nfc_cfg_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_set(evt_set),
        .irq(irq), .page_bytes(page_bytes), .block_bytes(block_bytes),
        .addr_cycles(addr_cycles), .dev_bytes(dev_bytes),
        .page_index(page_index), .bus_16bit(bus_16bit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        @(negedge clk);
        chk("R12 rsp_valid", 64'(rsp_valid), 64'd1);
        d = rsp_rdata;
        req_valid = 1'b0; req_be = 4'hF;
    endtask

    task automatic pulse(input logic [3:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    function automatic logic exp_irq(input logic [7:0] ien, input logic [3:0] st);
        return ien[7] & (|(ien[3:0] & st));
    endfunction

    task automatic check_reset_outputs(input string tag);
        chk({tag, " irq"}, 64'(irq), 64'd0);
        chk({tag, " page_bytes"}, 64'(page_bytes), 64'd512);
        chk({tag, " block_bytes"}, 64'(block_bytes), 64'd8192);
        chk({tag, " addr_cycles"}, 64'(addr_cycles), 64'd3);
        chk({tag, " dev_bytes"}, 64'(dev_bytes), 64'd1 << 24);
        chk({tag, " bus_16bit"}, 64'(bus_16bit), 64'd0);
        chk({tag, " page_index"}, 64'(page_index), 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        check_reset_outputs("R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R11: state after reset
        check_reset_outputs("R11 after reset");
        chk("R12 idle rsp_valid", 64'(rsp_valid), 64'd0);
        rd(12'h000, d); chk("R11 status", 64'(d), 64'd0);
        rd(12'h008, d); chk("R11 ien", 64'(d), 64'd0);
        rd(12'h010, d); chk("R11 geometry", 64'(d), 64'd0);
        rd(12'h018, d); chk("R11 burst", 64'(d), 64'd0);

        // R1 R2 R3: full sweep of geometry fields
        for (int ps = 0; ps < 4; ps++)
            for (int bs = 0; bs < 4; bs++)
                for (int ac = 0; ac < 4; ac++)
                    for (int ds = 0; ds < 16; ds++) begin
                        logic [31:0] v;
                        logic [63:0] pg;
                        v = 32'hA00C_F003 | (32'(bs) << 16) | (32'(ac) << 10)
                            | (32'(ps) << 8) | (32'(ds) << 4);
                        v = v & ~32'h0003_0FF0 | (32'(bs) << 16) | (32'(ac) << 10)
                            | (32'(ps) << 8) | (32'(ds) << 4);
                        wr(12'h010, v);
                        pg = (ps == 0) ? 64'd512 : (ps == 2) ? 64'd4096 : 64'd2048;
                        chk("R1 page_bytes", 64'(page_bytes), pg);
                        chk("R2 block_bytes", 64'(block_bytes), pg << (4 + bs));
                        chk("R3 addr_cycles", 64'(addr_cycles), 64'(3 + ac));
                        chk("R3 dev_bytes", 64'(dev_bytes), 64'd1 << (24 + ds));
                    end
        wr(12'h010, 32'h1234_5678);
        rd(12'h010, d); chk("R8 geometry readback", 64'(d), 64'h1234_5678);

        // R4: page index masking
        wr(12'h014, 32'hFFFF_FFFF);
        chk("R4 page_index all ones", 64'(page_index), 64'h03FF_FFFF);
        rd(12'h014, d); chk("R4 page readback", 64'(d), 64'h03FF_FFFF);
        wr(12'h014, 32'hDEAD_BEEF);
        rd(12'h014, d); chk("R4 page readback 2", 64'(d), 64'h02AD_BEEF);

        // R8: flow control and burst
        wr(12'h00C, 32'h0000_0010);
        chk("R8 bus_16bit set", 64'(bus_16bit), 64'd1);
        wr(12'h00C, 32'hFFFF_FFEF);
        chk("R8 bus_16bit clear", 64'(bus_16bit), 64'd0);
        rd(12'h00C, d); chk("R8 flow readback", 64'(d), 64'hFFFF_FFEF);
        wr(12'h018, 32'hCAFE_F00D);
        rd(12'h018, d); chk("R8 burst readback", 64'(d), 64'hCAFE_F00D);

        // R9: fixed words
        rd(12'h020, d); chk("R9 revision", 64'(d), 64'h0001_0100);
        rd(12'h024, d); chk("R9 hw config", 64'(d), 64'h0008_1601);
        rd(12'h028, d); chk("R9 page count", 64'(d), 64'd1);
        rd(12'h02C, d); chk("R9 pio ready", 64'(d), 64'd1);

        // R5 R7: enable x status sweep
        for (int g = 0; g < 2; g++)
            for (int en = 0; en < 16; en++)
                for (int st = 0; st < 16; st++) begin
                    logic [7:0] ev;
                    wr(12'h004, 32'h0000_000F);
                    pulse(4'(st));
                    ev = 8'((g << 7) | en);
                    wr(12'h008, 32'(ev) | 32'hFFFF_FF70);
                    chk("R5 irq", 64'(irq), 64'(exp_irq(ev, 4'(st))));
                    rd(12'h000, d); chk("R7 status", 64'(d), 64'(st) << 2);
                    rd(12'h008, d); chk("R5 ien masked", 64'(d), 64'(ev));
                end

        // R6: clearing
        wr(12'h008, 32'h0000_008F);
        pulse(4'hF);
        chk("R6 irq all set", 64'(irq), 64'd1);
        wr(12'h004, 32'h0000_0005);
        rd(12'h000, d); chk("R6 partial clear", 64'(d), 64'h28);
        chk("R6 irq after partial", 64'(irq), 64'd1);
        wr(12'h004, 32'hFFFF_FFF0);
        rd(12'h000, d); chk("R6 high bits no effect", 64'(d), 64'h28);
        rd(12'h004, d); chk("R6 clear reads zero", 64'(d), 64'd0);
        wr(12'h004, 32'h0000_000A);
        rd(12'h000, d); chk("R6 full clear", 64'(d), 64'd0);
        chk("R6 irq dropped", 64'(irq), 64'd0);
        pulse(4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h004; req_wdata = 32'hF; evt_set = 4'h1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; evt_set = '0;
        chk("R6 event beats clear irq", 64'(irq), 64'd1);
        rd(12'h000, d); chk("R6 event beats clear", 64'(d), 64'h04);

        // R10: narrow and misaligned accesses
        wr(12'h010, 32'h0000_0000);
        wr(12'h010, 32'h0003_0200, 4'h3);
        chk("R10 narrow write page", 64'(page_bytes), 64'd512);
        wr(12'h011, 32'h0003_0200);
        chk("R10 misaligned write block", 64'(block_bytes), 64'd8192);
        wr(12'h008, 32'h0000_0000, 4'hE);
        chk("R10 narrow ien write irq", 64'(irq), 64'd1);
        rd(12'h020, d, 4'h1); chk("R10 narrow read zero", 64'(d), 64'd0);
        rd(12'h022, d); chk("R10 misaligned read zero", 64'(d), 64'd0);
        rd(12'h03C, d); chk("R10 unmapped read zero", 64'(d), 64'd0);

        // R11: reset mid-run
        wr(12'h014, 32'h0000_0123);
        wr(12'h00C, 32'h0000_0010);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_reset_outputs("R11 second reset");
        rst_n = 1'b1;
        rd(12'h000, d); chk("R11 status after second reset", 64'(d), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule